// File: doc/BRIEF.md
# Two-Wire Output-Enable Control Register Slave

This block is a write-only two-wire serial slave that holds the control state of a differential clock fan-out stage. Over a shared clock line and an open-drain data line, a host addresses the slave, sends a command code byte, sends a byte count, and then sends up to that many data bytes. The data bytes land in three 8-bit control registers, in order, starting at register 0.

The registers drive six per-pair output enables and one test-select bit. A bit value of 1 enables its output pair. The bits that feed the pairs sit at fixed positions that the downstream output drivers decode. The slave samples both bus lines with the system clock. It detects START and STOP conditions, acknowledges each accepted byte, and ignores every transaction that is not a write to its own address.

Top module: `twowire_ctrl_regs`

## Requirements
- R1: After reset the registers hold reg0 = 0xFF, reg1 = 0xC0 and reg2 = 0xC0. All six `pair_en_o` bits are therefore 1 and `test_sel_o` is 1.
- R2: A START followed by an address byte whose upper 7 bits equal `SLAVE_ADDR` and whose LSB (write flag) is 0 is acknowledged. The slave asserts `sda_oe_o` during the 9th SCL high phase.
- R3: If the address does not match, or its LSB is 1 (read), the slave gives no acknowledge for that byte or for any later byte, and no register changes until the next START.
- R4: The first byte after the address is a command code and the second is a byte count. Both are acknowledged and neither is written to any register.
- R5: Data bytes are received MSB first and written to reg0, reg1 and reg2 in order. In reg0, bit 7 drives pair 0, bit 6 drives pair 1, bit 3 drives pair 2, bit 2 drives pair 5 and bit 0 drives pair 4.
- R6: reg1 bit 6 drives pair 3. reg2 bit 7 drives `test_sel_o`, where 0 selects the leakage test and 1 selects normal operation.
- R7: Data bytes past the byte count, or past reg2, are acknowledged and then discarded.
- R8: A STOP at any point ends the transaction. Bytes already completed stay written, and a partially received byte is not written.
- R9: A repeated START during a transaction restarts the address phase.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. SDA changes while SCL is low are treated as data and never as bus conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial bus clock line |
| sda_i | input | 1 | Serial bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low (open-drain acknowledge) |
| pair_en_o | output | 6 | Per-pair output enables, index = pair number |
| test_sel_o | output | 1 | Test select, 0 = leakage test, 1 = normal |

## Verification
The bench targets the byte sequencing edges, because an off-by-one there would write to the wrong register:
- It sends command and count bytes with distinctive values, which catches a design that writes the header into reg0.
- It sends more data bytes than the count allows, and a count larger than three. A design that failed to clamp would either corrupt registers or stop acknowledging.
- It sends a foreign address and a read address. A design that leaked these would acknowledge bytes or change outputs.

It also covers the bus conditions themselves:
- A STOP arriving inside a data byte, and a repeated START. A design that latched partial bytes, or did not rearm, would show the wrong enables.
- SDA toggles while SCL is low. A design that read these as bus conditions would start a transaction.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_CNT, ST_DATA, ST_DROP
  } tw_state_e;

  function automatic logic [7:0] reg_default(input int idx);
    return (idx == 0) ? 8'hFF : 8'hC0;
  endfunction
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES:0] scl_sr, sda_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[STAGES-1:0], scl_i};
      sda_sr <= {sda_sr[STAGES-1:0], sda_i};
    end
  end

  logic scl_now, scl_prev, sda_now, sda_prev;
  assign scl_now  = scl_sr[STAGES-1];
  assign scl_prev = scl_sr[STAGES];
  assign sda_now  = sda_sr[STAGES-1];
  assign sda_prev = sda_sr[STAGES];

  assign sda_o      = sda_now;
  assign scl_rise_o = scl_now & ~scl_prev;
  assign scl_fall_o = ~scl_now & scl_prev;
  // bus conditions only while SCL stays high across the SDA edge
  assign start_o    = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_o     = scl_now & scl_prev & ~sda_prev & sda_now;
endmodule

// File: rtl/tw_byte_engine.sv
module tw_byte_engine
  import tw_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter int         NUM_REGS   = 3,
  parameter int         IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o
);
  localparam logic [7:0] NREG8 = 8'(NUM_REGS);

  tw_state_e  state_q;
  logic [3:0] bit_cnt_q;
  logic [7:0] shreg_q, count_q, idx_q;
  logic       ack_ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      count_q   <= '0;
      idx_q     <= '0;
      ack_ph_q  <= 1'b0;
      sda_oe_o  <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        ack_ph_q  <= 1'b0;
        sda_oe_o  <= 1'b0;
      end else if (stop_i) begin
        state_q   <= ST_IDLE;
        bit_cnt_q <= '0;
        ack_ph_q  <= 1'b0;
        sda_oe_o  <= 1'b0;
      end else if (state_q != ST_IDLE && state_q != ST_DROP) begin
        if (scl_rise_i && !ack_ph_q && bit_cnt_q < 4'd8) begin
          shreg_q   <= {shreg_q[6:0], sda_i};
          bit_cnt_q <= bit_cnt_q + 4'd1;
        end else if (scl_fall_i && ack_ph_q) begin
          // end of ninth pulse: release the line, next byte
          ack_ph_q  <= 1'b0;
          sda_oe_o  <= 1'b0;
          bit_cnt_q <= '0;
        end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
          case (state_q)
            ST_ADDR: begin
              if (shreg_q[7:1] == SLAVE_ADDR && !shreg_q[0]) begin
                ack_ph_q <= 1'b1;
                sda_oe_o <= 1'b1;
                state_q  <= ST_CMD;
              end else begin
                state_q  <= ST_DROP;
              end
            end
            ST_CMD: begin
              ack_ph_q <= 1'b1;
              sda_oe_o <= 1'b1;
              state_q  <= ST_CNT;
            end
            ST_CNT: begin
              ack_ph_q <= 1'b1;
              sda_oe_o <= 1'b1;
              count_q  <= shreg_q;
              idx_q    <= '0;
              state_q  <= ST_DATA;
            end
            ST_DATA: begin
              ack_ph_q <= 1'b1;
              sda_oe_o <= 1'b1;
              if (idx_q < count_q && idx_q < NREG8) begin
                wr_en_o   <= 1'b1;
                wr_idx_o  <= IDX_W'(idx_q);
                wr_data_o <= shreg_q;
              end
              if (idx_q != 8'hFF) idx_q <= idx_q + 8'd1;
            end
            default: state_q <= ST_DROP;
          endcase
        end
      end
    end
  end

  a_r2_ack_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> ack_ph_q);
  a_r3_drop_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DROP) |-> !sda_oe_o);
  a_r4_write_only_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (state_q == ST_DATA));
  a_r7_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (32'(wr_idx_o) < NUM_REGS));
  a_r9_start_rearms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_ADDR && !sda_oe_o));
  a_r8_stop_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (state_q == ST_IDLE && !wr_en_o));
endmodule

// File: rtl/tw_reg_file.sv
module tw_reg_file
  import tw_pkg::*;
#(
  parameter int NUM_REGS = 3,
  parameter int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [7:0]            wr_data_i,
  output logic [NUM_REGS*8-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       q <= reg_default(g);
      else if (wr_en_i && 32'(wr_idx_i) == g)            q <= wr_data_i;
    end
    assign regs_o[g*8 +: 8] = q;
  end

  a_r8_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_o));
endmodule

// File: rtl/twowire_ctrl_regs.sv
module twowire_ctrl_regs
  import tw_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h69,
  parameter int         SYNC_STAGES = 2,
  parameter int         NUM_PAIRS   = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  output logic [NUM_PAIRS-1:0] pair_en_o,
  output logic                 test_sel_o
);
  localparam int NUM_REGS = 3;
  localparam int IDX_W    = $clog2(NUM_REGS);

  logic sda_s, scl_rise, scl_fall, start, stop;
  logic wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0] wr_data;
  logic [NUM_REGS*8-1:0] regs;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  tw_byte_engine #(.SLAVE_ADDR(SLAVE_ADDR), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_eng (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .sda_oe_o,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  tw_reg_file #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .regs_o(regs)
  );

  // fixed bit positions decoded by the pair drivers
  logic [7:0] r0, r1, r2;
  assign r0 = regs[7:0];
  assign r1 = regs[15:8];
  assign r2 = regs[23:16];

  logic [5:0] map;
  assign map = {r0[2], r0[0], r1[6], r0[3], r0[6], r0[7]};
  assign pair_en_o  = NUM_PAIRS'(map);
  assign test_sel_o = r2[7];

  a_r10_no_cond_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start || stop) |-> $past(scl_i));
endmodule

// File: tb/twowire_ctrl_regs_bench.sv
`timescale 1ns/1ps
module twowire_ctrl_regs_bench;
  localparam int Q = 10;
  localparam logic [6:0] ADDR = 7'h69;

  logic clk = 0, rst_ni = 0;
  logic scl = 1, sda_m = 1;
  logic sda_oe;
  logic [5:0] pair_en;
  logic test_sel;
  wire  sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  twowire_ctrl_regs u_twowire_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .pair_en_o(pair_en), .test_sel_o(test_sel)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] m [3];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_pairs();
    return {m[0][2], m[0][0], m[1][6], m[0][3], m[0][6], m[0][7]};
  endfunction

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1; wq(Q); scl = 1; wq(Q); sda_m = 0; wq(Q); scl = 0; wq(Q);
  endtask
  task automatic bus_stop();
    scl = 0; sda_m = 0; wq(Q); scl = 1; wq(Q); sda_m = 1; wq(2*Q);
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      scl = 0; wq(Q); sda_m = b[i]; wq(Q); scl = 1; wq(2*Q);
    end
    scl = 0; wq(Q); sda_m = 1; wq(Q); scl = 1; wq(Q);
    ack = sda_oe; wq(Q); scl = 0; wq(Q);
  endtask
  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      scl = 0; wq(Q); sda_m = b[i]; wq(Q); scl = 1; wq(2*Q);
    end
  endtask
  task automatic chk_out(input string req);
    chk({req, " pairs"}, 32'(pair_en), 32'(exp_pairs()));
    chk({req, " test"}, 32'(test_sel), 32'(m[2][7]));
  endtask

  typedef struct packed {
    logic [6:0]  addr;
    logic        rw;
    logic [7:0]  cnt;
    logic [2:0]  nd;
    logic [31:0] data;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{ADDR,    1'b0, 8'd3, 3'd3, 32'h0000_0000},
    '{ADDR,    1'b0, 8'd1, 3'd1, 32'h8000_0000},
    '{7'h2A,   1'b0, 8'd3, 3'd3, 32'hFFFF_FF00},
    '{ADDR,    1'b1, 8'd3, 3'd3, 32'hFFFF_FF00},
    '{ADDR,    1'b0, 8'd2, 3'd4, 32'h4D40_AABB},
    '{ADDR,    1'b0, 8'd5, 3'd4, 32'h8000_8011},
    '{ADDR,    1'b0, 8'd3, 3'd3, 32'hFFFF_8000}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic exp_ack;
    for (int i = 0; i < 3; i++) m[i] = (i == 0) ? 8'hFF : 8'hC0;
    wq(5); rst_ni = 1; wq(5);
    chk_out("R1 reset");
    chk("R1 sda idle", 32'(sda_oe), 0);

    // table walk
    for (int v = 0; v < 7; v++) begin
      exp_ack = (VECS[v].addr == ADDR) && !VECS[v].rw;
      bus_start();
      send_byte({VECS[v].addr, VECS[v].rw}, ack);
      chk(exp_ack ? "R2 addr ack" : "R3 addr nack", 32'(ack), 32'(exp_ack));
      send_byte(8'hA5, ack);
      chk(exp_ack ? "R4 cmd ack" : "R3 cmd nack", 32'(ack), 32'(exp_ack));
      send_byte(VECS[v].cnt, ack);
      chk(exp_ack ? "R4 cnt ack" : "R3 cnt nack", 32'(ack), 32'(exp_ack));
      for (int d = 0; d < int'(VECS[v].nd); d++) begin
        logic [7:0] b;
        b = VECS[v].data[31-8*d -: 8];
        send_byte(b, ack);
        chk(exp_ack ? "R7 data ack" : "R3 data nack", 32'(ack), 32'(exp_ack));
        if (exp_ack && d < int'(VECS[v].cnt) && d < 3) m[d] = b;
      end
      bus_stop();
      chk_out(exp_ack ? "R5 R6 R7 table" : "R3 table");
    end

    // R8: stop inside a data byte keeps finished bytes, drops partial
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    send_byte(8'h00, ack);
    send_byte(8'd3, ack);
    send_byte(8'h08, ack); m[0] = 8'h08;
    send_bits(8'h00, 4);
    bus_stop();
    chk_out("R8 stop mid-byte");

    // R9: repeated start restarts address phase
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    send_byte(8'h11, ack);
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    chk("R9 readdress ack", 32'(ack), 1);
    send_byte(8'h22, ack);
    send_byte(8'd1, ack);
    send_byte(8'h81, ack); m[0] = 8'h81;
    bus_stop();
    chk_out("R9 repeated start");

    // R10: SDA wiggles with SCL low are not START; bytes ignored
    scl = 0; wq(Q);
    for (int k = 0; k < 4; k++) begin sda_m = ~sda_m; wq(Q); end
    send_byte({ADDR, 1'b0}, ack);
    chk("R10 no start no ack", 32'(ack), 0);
    send_byte(8'h00, ack);
    send_byte(8'd1, ack);
    send_byte(8'h00, ack);
    bus_stop();
    chk_out("R10 idle unchanged");

    // R1: reset restores defaults
    rst_ni = 0; wq(3); rst_ni = 1; wq(3);
    for (int i = 0; i < 3; i++) m[i] = (i == 0) ? 8'hFF : 8'hC0;
    chk_out("R1 re-reset");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule